// File: doc/BRIEF.md
# Boundary Scan Test Controller

This block is the serial test port of a programmable logic device. It has four serial pins: a data input, a data output, a mode select and a test clock. It has no dedicated test-reset pin. A power-on reset and the mode-select sequence are the only ways to reset it. A sixteen-state controller walks the standard path through the instruction and data scan columns. A 4-bit instruction then chooses which data register sits between the serial input and the serial output:

- a one-bit bypass stage;
- a boundary register spanning a parameterised number of I/O cells;
- an 8-bit probe-select register, which routes one internal node to a debug probe output.

Shift stages capture and shift on the rising test-clock edge. Update latches and the serial output change on the falling edge. The output enable is high only in the two shift states. Several devices can be chained output-to-input and share mode select and test clock. Every instance then walks the same state sequence.

Top module: `bscan_tap`

## Requirements
- R1: While `por_n` is low the controller is in its reset state. In that state `tdo_oe` is 0, `probe_sel` is 0 and `pin_out` equals `core_out`. The active instruction is bypass, so the first data scan after power-on behaves as in R4.
- R2: From any state, five consecutive rising `tck` edges with `tms` high reach the test-logic-reset state.
- R3: Capture in the instruction column loads 4'b0001. Shifting then presents that value on `tdo` least significant bit first, while the new code enters from `tdi`.
- R4: The instruction code 4'b1111 selects bypass, and every code that is not 4'b0000, 4'b0001 or 4'b1000 acts the same way. In bypass the data path is one stage that captures 0. The first bit out is therefore 0, followed by `tdi` delayed by one clock.
- R5: `tdo` and `tdo_oe` change only on the falling `tck` edge. `tdo_oe` is 1 exactly while the controller is in one of the two shift states.
- R6: The code 4'b0001 (sample/preload) captures `pin_in` into the boundary register, cell 0 shifted out first. The update latch loads the scanned-in value, but `pin_out` keeps following `core_out`.
- R7: The code 4'b0000 (external test) drives `pin_out` from the boundary update latch, and changes on `core_out` have no effect. Once another instruction is active, `pin_out` follows `core_out` again.
- R8: The code 4'b1000 (probe) puts the probe-select register in the scan path. In that path capture loads the current `probe_sel`, and update loads the scanned value into `probe_sel`. `probe_out` equals `probe_nodes[probe_sel]`, or 0 when `probe_sel` is not below NODES.
- R9: `probe_sel` changes only in the data update state while the probe instruction is active. Data scans under any other instruction leave it unchanged.
- R10: Entering test-logic-reset loads bypass into the instruction register. Any active external test therefore ends, while `probe_sel` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`, high in the shift states |
| core_out | input | NIO | Values the core logic wants on the pins |
| pin_in | input | NIO | Values present at the pins, for capture |
| pin_out | output | NIO | Values driven onto the pins |
| probe_nodes | input | NODES | Internal nodes available to the probe |
| probe_sel | output | PW | Selected probe node index |
| probe_out | output | 1 | Value of the selected internal node |

## Verification
The bench builds the block with NIO=5 and NODES=12, keeping PW at 8. Because the selector can name index 200, the out-of-range probe case is reachable, and a narrow boundary register keeps each preload and external-test scan short. With these sizes every instruction, an undefined code and a mode-select reset issued from the middle of a data shift are all checked in one short run.

// File: rtl/bscan_tap.sv
`timescale 1ns/1ps
module bscan_tap #(
  parameter int NIO   = 6,
  parameter int PW    = 8,
  parameter int NODES = 16
) (
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             por_n,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [NIO-1:0]   core_out,
  input  logic [NIO-1:0]   pin_in,
  output logic [NIO-1:0]   pin_out,
  input  logic [NODES-1:0] probe_nodes,
  output logic [PW-1:0]    probe_sel,
  output logic             probe_out
);

  typedef enum logic [3:0] {
    EX2DR = 4'h0, EX1DR = 4'h1, SHDR = 4'h2, PAUDR = 4'h3,
    SELIR = 4'h4, UPDR  = 4'h5, CAPDR = 4'h6, SELDR = 4'h7,
    EX2IR = 4'h8, EX1IR = 4'h9, SHIR = 4'hA, PAUIR = 4'hB,
    RTI   = 4'hC, UPIR  = 4'hD, CAPIR = 4'hE, TLR   = 4'hF
  } tap_t;

  localparam logic [3:0] OP_EXTEST = 4'b0000;
  localparam logic [3:0] OP_SAMPLE = 4'b0001;
  localparam logic [3:0] OP_PROBE  = 4'b1000;
  localparam logic [3:0] OP_BYPASS = 4'b1111;

  tap_t state, nxt;
  logic [3:0]     ir_sr, ir;
  logic           byp;
  logic [NIO-1:0] bsr_sr, bsr_upd;
  logic [PW-1:0]  prb_sr;
  logic           dr_out;

  wire op_ext = (ir == OP_EXTEST);
  wire op_smp = (ir == OP_SAMPLE);
  wire op_prb = (ir == OP_PROBE);
  wire op_bsr = op_ext | op_smp;

  always_comb begin
    case (state)
      TLR:     nxt = tms ? TLR   : RTI;
      RTI:     nxt = tms ? SELDR : RTI;
      SELDR:   nxt = tms ? SELIR : CAPDR;
      CAPDR:   nxt = tms ? EX1DR : SHDR;
      SHDR:    nxt = tms ? EX1DR : SHDR;
      EX1DR:   nxt = tms ? UPDR  : PAUDR;
      PAUDR:   nxt = tms ? EX2DR : PAUDR;
      EX2DR:   nxt = tms ? UPDR  : SHDR;
      UPDR:    nxt = tms ? SELDR : RTI;
      SELIR:   nxt = tms ? TLR   : CAPIR;
      CAPIR:   nxt = tms ? EX1IR : SHIR;
      SHIR:    nxt = tms ? EX1IR : SHIR;
      EX1IR:   nxt = tms ? UPIR  : PAUIR;
      PAUIR:   nxt = tms ? EX2IR : PAUIR;
      EX2IR:   nxt = tms ? UPIR  : SHIR;
      UPIR:    nxt = tms ? SELDR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) state <= TLR;
    else        state <= nxt;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sr  <= 4'b0001;
      byp    <= 1'b0;
      bsr_sr <= '0;
      prb_sr <= '0;
    end else begin
      if (state == CAPIR)     ir_sr <= 4'b0001;
      else if (state == SHIR) ir_sr <= {tdi, ir_sr[3:1]};
      if (state == CAPDR) begin
        byp <= 1'b0;
        if (op_bsr) bsr_sr <= pin_in;
        if (op_prb) prb_sr <= probe_sel;
      end else if (state == SHDR) begin
        byp <= tdi;
        if (op_bsr) bsr_sr <= {tdi, bsr_sr[NIO-1:1]};
        if (op_prb) prb_sr <= {tdi, prb_sr[PW-1:1]};
      end
    end
  end

  assign dr_out = op_bsr ? bsr_sr[0] : op_prb ? prb_sr[0] : byp;

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      ir        <= OP_BYPASS;
      bsr_upd   <= '0;
      probe_sel <= '0;
      tdo       <= 1'b0;
      tdo_oe    <= 1'b0;
    end else begin
      if (state == TLR)       ir <= OP_BYPASS;
      else if (state == UPIR) ir <= ir_sr;
      if (state == UPDR && op_bsr) bsr_upd   <= bsr_sr;
      if (state == UPDR && op_prb) probe_sel <= prb_sr;
      tdo_oe <= (state == SHIR) || (state == SHDR);
      if (state == SHIR)      tdo <= ir_sr[0];
      else if (state == SHDR) tdo <= dr_out;
    end
  end

  assign pin_out = op_ext ? bsr_upd : core_out;

  always_comb begin
    probe_out = 1'b0;
    for (int i = 0; i < NODES; i++)
      if (probe_sel == PW'(i)) probe_out = probe_nodes[i];
  end

endmodule

module bscan_tap_chk #(
  parameter int NIO = 6,
  parameter int PW  = 8
) (
  input logic           tck,
  input logic           por_n,
  input logic           tms,
  input logic [3:0]     state,
  input logic [3:0]     ir,
  input logic [3:0]     ir_sr,
  input logic           tdo_oe,
  input logic [NIO-1:0] pin_out,
  input logic [NIO-1:0] core_out,
  input logic [PW-1:0]  probe_sel
);
  logic [2:0] ones;
  always_ff @(posedge tck or negedge por_n)
    if (!por_n)   ones <= '0;
    else if (!tms) ones <= '0;
    else if (ones != 3'd5) ones <= ones + 3'd1;

  p_five_ones_tlr_r2: assert property (@(posedge tck) disable iff (!por_n)
    (ones == 3'd5) |-> (state == 4'hF));

  p_capture_ir_r3: assert property (@(posedge tck) disable iff (!por_n)
    (state == 4'hE) |=> (ir_sr == 4'b0001));

  p_oe_shift_r5: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == ((state == 4'hA) || (state == 4'h2)));

  p_core_pins_r7: assert property (@(posedge tck) disable iff (!por_n)
    (ir != 4'b0000) |-> (pin_out == core_out));

  p_probe_hold_r9: assert property (@(posedge tck) disable iff (!por_n)
    !((state == 4'h5) && (ir == 4'b1000)) |-> $stable(probe_sel));

  p_tlr_bypass_r10: assert property (@(posedge tck) disable iff (!por_n)
    (state == 4'hF) |-> (ir == 4'hF));
endmodule

bind bscan_tap bscan_tap_chk #(.NIO(NIO), .PW(PW)) u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .state(state), .ir(ir),
  .ir_sr(ir_sr), .tdo_oe(tdo_oe), .pin_out(pin_out),
  .core_out(core_out), .probe_sel(probe_sel)
);

// File: tb/bscan_tap_bench.sv
`timescale 1ns/1ps
module bscan_tap_bench;
  localparam int NIO = 5, PW = 8, NODES = 12;

  logic tck = 0, tms = 1, tdi = 0, por_n = 0;
  logic tdo, tdo_oe, probe_out;
  logic [NIO-1:0] core_out = 5'b10010, pin_in = 5'b10110, pin_out;
  logic [NODES-1:0] probe_nodes = 12'hA6D;
  logic [PW-1:0] probe_sel;

  bscan_tap #(.NIO(NIO), .PW(PW), .NODES(NODES)) u_bscan_tap (
    .tck(tck), .tms(tms), .tdi(tdi), .por_n(por_n), .tdo(tdo), .tdo_oe(tdo_oe),
    .core_out(core_out), .pin_in(pin_in), .pin_out(pin_out),
    .probe_nodes(probe_nodes), .probe_sel(probe_sel), .probe_out(probe_out));

  always #2.5 tck = ~tck;

  typedef struct { logic oe; logic val; bit use_val; string tag; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  initial forever begin
    @(negedge tck); #2;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (tdo_oe !== it.oe) begin
        errors++; $display("FAIL %s tdo_oe got %b exp %b", it.tag, tdo_oe, it.oe);
      end else if (it.use_val && tdo !== it.val) begin
        errors++; $display("FAIL %s tdo got %b exp %b", it.tag, tdo, it.val);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++; $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); #0.5; tms = m; tdi = d;
  endtask

  task automatic step_x(input logic m, input logic d, input logic oe, input logic v,
                        input bit use_v, input string tag);
    item_t it;
    @(negedge tck); #0.5; tms = m; tdi = d;
    it.oe = oe; it.val = v; it.use_val = use_v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic load_ir(input logic [3:0] code);
    step(1, 0); step(1, 0); step(0, 0);
    step_x(0, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 4; i++)
      step_x(i == 3, code[i], 1, (i == 0), 1, "R3");
    step_x(1, 0, 0, 0, 0, "R5");
    step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [15:0] din, input logic [15:0] exp,
                         input string tag);
    step(1, 0); step(0, 0);
    step_x(0, 0, 0, 0, 0, "R5");
    for (int i = 0; i < n; i++)
      step_x(i == n - 1, din[i], 1, exp[i], 1, tag);
    step(1, 0);
    step_x(0, 0, 0, 0, 0, "R5");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge tck);
    #0.5;
    chk("R1 oe", 16'(tdo_oe), 0);
    chk("R1 probe_sel", 16'(probe_sel), 0);
    chk("R1 pins", 16'(pin_out), 16'(core_out));
    chk("R1 probe_out", 16'(probe_out), 16'(probe_nodes[0]));
    por_n = 1;
    step(0, 0);
    scan_dr(4, 16'b1011, 16'b0110, "R1 R4 bypass");

    load_ir(4'b0001);
    scan_dr(NIO, 16'b01011, 16'(pin_in), "R6 capture");
    chk("R6 pins follow core", 16'(pin_out), 16'(core_out));

    load_ir(4'b0000);
    chk("R7 preload drives", 16'(pin_out), 16'b01011);
    pin_in = 5'b00111;
    scan_dr(NIO, 16'b11100, 16'b00111, "R7 capture");
    chk("R7 update drives", 16'(pin_out), 16'b11100);
    core_out = 5'b01101;
    #1;
    chk("R7 core ignored", 16'(pin_out), 16'b11100);

    load_ir(4'b1000);
    chk("R7 released", 16'(pin_out), 16'(core_out));
    scan_dr(PW, 16'd5, 16'd0, "R8 scan");
    chk("R8 sel", 16'(probe_sel), 5);
    chk("R8 node5", 16'(probe_out), 16'(probe_nodes[5]));
    scan_dr(PW, 16'd200, 16'd5, "R8 readback");
    chk("R8 out of range", 16'(probe_out), 0);
    scan_dr(PW, 16'd4, 16'd200, "R8 readback2");
    chk("R8 node4", 16'(probe_out), 16'(probe_nodes[4]));

    load_ir(4'b0110);
    scan_dr(3, 16'b011, 16'b110, "R4 undefined");
    chk("R9 hold undefined", 16'(probe_sel), 4);
    load_ir(4'b0001);
    scan_dr(NIO, 16'b11111, 16'(pin_in), "R6 sample2");
    chk("R9 hold sample", 16'(probe_sel), 4);

    load_ir(4'b0000);
    chk("R7 extest again", 16'(pin_out), 16'b11111);
    step(1, 0); step(0, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    chk("R2 R10 pins back", 16'(pin_out), 16'(core_out));
    chk("R10 probe kept", 16'(probe_sel), 4);
    scan_dr(3, 16'b101, 16'b010, "R2 R10 bypass");

    repeat (2) @(negedge tck);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule